// File: doc/BRIEF.md
# Receive Descriptor Status Writeback

This block assembles the 32-bit status word that a receive DMA engine writes back into a descriptor once the buffer that descriptor covers is full. It watches the inbound stream handshake and sideband (destination, identifier, user bits and the end-of-packet marker). It also takes three error pulses from the data mover. Each time the data mover signals that a buffer is finished, the block emits one status word with a one-cycle write strobe.

A packet may span several chained buffers. The block captures the packet's sideband once, on its first accepted beat, and repeats it in every buffer of that packet. It marks the buffer that holds the packet's start and the buffer that holds its end. It merges any error seen during the buffer into that buffer's word and always sets the completion bit. Descriptor fetch and the memory write of the word are handled elsewhere.

Top module: `rx_status_wb`

## Requirements
- R1: While reset is low and in the first cycle after it, `sts_wr` is 0 and `sts_word` is 0.
- R2: Each cycle with `buf_done` high gives exactly one cycle of `sts_wr` high, on the following cycle. `sts_wr` is never high otherwise.
- R3: A beat is accepted only when `s_valid` and `s_ready` are both high. The first accepted beat after reset, or after an accepted beat with `s_last` high, supplies destination in bits 4:0, identifier in bits 12:8 and user bits in bits 19:16. Beats with `s_ready` low change nothing.
- R4: Every later buffer of the same packet reports the sideband captured at the packet's first beat, whatever the stream sideband does mid-packet.
- R5: Bit 27 is 1 only in the word of the buffer during which a packet's first beat was accepted. This includes a first beat accepted in the same cycle as `buf_done`.
- R6: Bit 26 is 1 only in the word of the buffer during which a beat with `s_last` was accepted. This includes the `buf_done` cycle.
- R7: A pulse on `err_int`, `err_slv` or `err_dec` at any cycle of a buffer, including its `buf_done` cycle, sets bit 28, 29 or 30 respectively in that buffer's word.
- R8: Error, start and end flags are cleared when a word is emitted, so they do not carry into the next buffer's word.
- R9: Every written word has bit 31 set and bits 7:5, 15:13 and 25:20 zero.
- R10: `sts_word` holds its value in every cycle where `sts_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | input | 1 | Stream beat ready (observed) |
| s_last | input | 1 | Stream end-of-packet marker |
| s_dest | input | 5 | Stream destination sideband |
| s_id | input | 5 | Stream identifier sideband |
| s_user | input | 4 | Stream user sideband |
| err_int | input | 1 | Internal length error pulse |
| err_slv | input | 1 | Slave error response pulse |
| err_dec | input | 1 | Decode error response pulse |
| buf_done | input | 1 | Current buffer finished, emit word |
| sts_word | output | 32 | Assembled status word |
| sts_wr | output | 1 | Status word write strobe |

## Verification
The word builder is exercised on a chain of buffers. The chain covers a single-beat packet, a packet that opens in one buffer, runs through a middle buffer and closes in a third, and a multi-beat packet carrying all three errors. Together they separate start-only, middle and end-only buffers, and show whether sideband is held or refreshed. Changing the stream sideband in middle buffers separates a captured value from a live one. An error raised in one buffer and absent in the next shows whether the flags clear. A beat stalled by a low ready, carrying a false end marker and bogus sideband, checks that only accepted beats count.

// File: rtl/rx_sts_pkg.sv
package rx_sts_pkg;
  localparam int DEST_W   = 5;
  localparam int ID_W     = 5;
  localparam int USER_W   = 4;
  localparam int ERR_W    = 3;
  localparam int WORD_W   = 32;
  localparam int DEST_LSB = 0;
  localparam int ID_LSB   = 8;
  localparam int USER_LSB = 16;
  localparam int EOP_BIT  = 26;
  localparam int SOP_BIT  = 27;
  localparam int ERR_LSB  = 28;
  localparam int CMP_BIT  = 31;
  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h03F0_E0E0;

  typedef struct packed {
    logic [USER_W-1:0] user;
    logic [ID_W-1:0]   id;
    logic [DEST_W-1:0] dest;
  } side_t;

  function automatic logic [WORD_W-1:0] pack_status(side_t sb, logic sop,
                                                    logic eop, logic [ERR_W-1:0] err);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DEST_LSB +: DEST_W] = sb.dest;
    w[ID_LSB   +: ID_W]   = sb.id;
    w[USER_LSB +: USER_W] = sb.user;
    w[EOP_BIT]            = eop;
    w[SOP_BIT]            = sop;
    w[ERR_LSB  +: ERR_W]  = err;
    w[CMP_BIT]            = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rx_sts_pkt_track.sv
module rx_sts_pkt_track
  import rx_sts_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  last,
  input  side_t side_in,
  output logic  first_beat,
  output logic  last_beat,
  output side_t side_out
);
  logic  pkt_open_q;
  side_t side_q;

  assign first_beat = beat && !pkt_open_q;
  assign last_beat  = beat && last;
  assign side_out   = first_beat ? side_in : side_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open_q <= 1'b0;
      side_q     <= '0;
    end else begin
      if (beat)       pkt_open_q <= !last;
      if (first_beat) side_q     <= side_in;
    end
  end
endmodule

// File: rtl/rx_sts_buf_flags.sv
module rx_sts_buf_flags
  import rx_sts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_beat,
  input  logic             last_beat,
  input  logic [ERR_W-1:0] err_in,
  input  logic             done,
  output logic             sop_eff,
  output logic             eop_eff,
  output logic [ERR_W-1:0] err_eff
);
  logic sop_q, eop_q;

  assign sop_eff = sop_q || first_beat;
  assign eop_eff = eop_q || last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n || done) begin
      sop_q <= 1'b0;
      eop_q <= 1'b0;
    end else begin
      sop_q <= sop_eff;
      eop_q <= eop_eff;
    end
  end

  for (genvar i = 0; i < ERR_W; i++) begin : g_err
    logic err_q;
    assign err_eff[i] = err_q || err_in[i];
    always_ff @(posedge clk) begin
      if (!rst_n || done) err_q <= 1'b0;
      else                err_q <= err_eff[i];
    end
  end
endmodule

// File: rtl/rx_status_wb.sv
module rx_status_wb
  import rx_sts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic              s_last,
  input  logic [DEST_W-1:0] s_dest,
  input  logic [ID_W-1:0]   s_id,
  input  logic [USER_W-1:0] s_user,
  input  logic              err_int,
  input  logic              err_slv,
  input  logic              err_dec,
  input  logic              buf_done,
  output logic [WORD_W-1:0] sts_word,
  output logic              sts_wr
);
  logic             beat;
  logic             first_beat;
  logic             last_beat;
  side_t            side_live;
  side_t            side_cur;
  logic             sop_eff;
  logic             eop_eff;
  logic [ERR_W-1:0] err_eff;

  assign beat      = s_valid && s_ready;
  assign side_live = '{user: s_user, id: s_id, dest: s_dest};

  rx_sts_pkt_track u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .last      (s_last),
    .side_in   (side_live),
    .first_beat(first_beat),
    .last_beat (last_beat),
    .side_out  (side_cur)
  );

  rx_sts_buf_flags u_flg (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_beat(first_beat),
    .last_beat (last_beat),
    .err_in    ({err_dec, err_slv, err_int}),
    .done      (buf_done),
    .sop_eff   (sop_eff),
    .eop_eff   (eop_eff),
    .err_eff   (err_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_word <= '0;
      sts_wr   <= 1'b0;
    end else begin
      sts_wr <= buf_done;
      if (buf_done) sts_word <= pack_status(side_cur, sop_eff, eop_eff, err_eff);
    end
  end
endmodule

// File: rtl/rx_sts_chk.sv
module rx_sts_chk
  import rx_sts_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              buf_done,
  input logic              first_beat,
  input logic              last_beat,
  input logic [WORD_W-1:0] sts_word,
  input logic              sts_wr
);
  logic up_q, fb_seen_q, lb_seen_q, exp_sop_q, exp_eop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q      <= 1'b0;
      fb_seen_q <= 1'b0;
      lb_seen_q <= 1'b0;
      exp_sop_q <= 1'b0;
      exp_eop_q <= 1'b0;
    end else begin
      up_q      <= 1'b1;
      fb_seen_q <= buf_done ? 1'b0 : (fb_seen_q | first_beat);
      lb_seen_q <= buf_done ? 1'b0 : (lb_seen_q | last_beat);
      if (buf_done) begin
        exp_sop_q <= fb_seen_q | first_beat;
        exp_eop_q <= lb_seen_q | last_beat;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) AST_QUIET_IN_RESET: assert (!sts_wr || !up_q); // R1
  end

  AST_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (sts_wr == $past(buf_done))); // R2
  AST_CMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> sts_word[CMP_BIT]); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> ((sts_word & RSVD_MASK) == '0)); // R9
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !sts_wr) |-> $stable(sts_word)); // R10
  AST_SOP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> (sts_word[SOP_BIT] == exp_sop_q)); // R5
  AST_EOP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> (sts_word[EOP_BIT] == exp_eop_q)); // R6
endmodule

bind rx_status_wb rx_sts_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_done  (buf_done),
  .first_beat(first_beat),
  .last_beat (last_beat),
  .sts_word  (sts_word),
  .sts_wr    (sts_wr)
);

// File: tb/sim_rx_status_wb.sv
`timescale 1ns/1ps
module sim_rx_status_wb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_ready = 1'b0, s_last = 1'b0;
  logic [4:0]  s_dest = '0, s_id = '0;
  logic [3:0]  s_user = '0;
  logic        err_int = 1'b0, err_slv = 1'b0, err_dec = 1'b0, buf_done = 1'b0;
  logic [31:0] sts_word;
  logic        sts_wr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rx_status_wb u0 (.*);

  // entry: {beats[2:0], last, dest[4:0], id[4:0], user[3:0], err[2:0]}
  localparam logic [20:0] VEC [5] = '{
    {3'd1, 1'b1, 5'h03, 5'h11, 4'hA, 3'b000},
    {3'd3, 1'b0, 5'h1F, 5'h00, 4'h5, 3'b001},
    {3'd2, 1'b0, 5'h01, 5'h02, 4'h3, 3'b000},
    {3'd2, 1'b1, 5'h07, 5'h07, 4'h7, 3'b110},
    {3'd4, 1'b1, 5'h0A, 5'h15, 4'hF, 3'b111}
  };

  logic       m_open = 1'b0;
  logic [4:0] m_dest = '0, m_id = '0;
  logic [3:0] m_user = '0;

  function automatic logic [31:0] expect_word(logic [4:0] d, logic [4:0] i, logic [3:0] u,
                                              logic sop, logic eop, logic [2:0] e);
    logic [31:0] w = 32'h8000_0000;
    w[4:0] = d; w[12:8] = i; w[19:16] = u;
    w[26] = eop; w[27] = sop;
    w[28] = e[0]; w[29] = e[1]; w[30] = e[2];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_buffer(int nb, logic last, logic [4:0] d, logic [4:0] i,
                            logic [3:0] u, logic [2:0] e, string req);
    logic sop;
    logic [31:0] exp, held;
    sop = !m_open;
    if (!m_open) begin m_dest = d; m_id = i; m_user = u; end
    m_open = !last;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_ready = 1'b1;
      s_dest = d + 5'(k); s_id = i + 5'(k); s_user = u + 4'(k);
      if (k == 0) begin s_dest = d; s_id = i; s_user = u; end
      s_last = last && (k == nb - 1);
      {err_dec, err_slv, err_int} = (k == 0) ? e : 3'b000;
      buf_done = (k == nb - 1);
    end
    @(negedge clk);
    s_valid = 1'b0; s_ready = 1'b0; s_last = 1'b0; buf_done = 1'b0;
    {err_dec, err_slv, err_int} = 3'b000;
    s_dest = 5'h15; s_id = 5'h0A; s_user = 4'h9;
    exp = expect_word(m_dest, m_id, m_user, sop, last, e);
    check({req, " R2 strobe"}, {31'd0, sts_wr}, 32'd1);
    check({req, " word"}, sts_word, exp);
    held = sts_word;
    @(negedge clk);
    check("R2 single strobe", {31'd0, sts_wr}, 32'd0);
    check("R10 word held", sts_word, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobe", {31'd0, sts_wr}, 32'd0);
    check("R1 reset word", sts_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {sts_wr, sts_word[30:0]}, 32'd0);

    // R3 R4 R5 R6 R7 R8 R9 exercised by the chain below
    for (int n = 0; n < 5; n++) begin
      logic [20:0] v = VEC[n];
      run_buffer(int'(v[20:18]), v[17], v[16:12], v[11:7], v[6:3], v[2:0], "R3 R4 R5 R6 R7 R8 R9");
    end

    // R3: stalled beat with last and bogus sideband is ignored
    @(negedge clk);
    s_valid = 1'b1; s_ready = 1'b0; s_last = 1'b1;
    s_dest = 5'h1E; s_id = 5'h1D; s_user = 4'hC;
    run_buffer(2, 1'b1, 5'h04, 5'h09, 4'h2, 3'b010, "R3 stalled beat");

    // R7 R8: error with no beats, then clean buffer
    @(negedge clk); err_dec = 1'b1; buf_done = 1'b1;
    @(negedge clk); err_dec = 1'b0; buf_done = 1'b0;
    check("R7 idle error", sts_word, expect_word(m_dest, m_id, m_user, 1'b0, 1'b0, 3'b100));
    @(negedge clk); buf_done = 1'b1;
    @(negedge clk); buf_done = 1'b0;
    check("R8 cleared", sts_word, expect_word(m_dest, m_id, m_user, 1'b0, 1'b0, 3'b000));
    check("R9 reserved zero", sts_word & 32'h03F0_E0E0, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule